// File: doc/BRIEF.md
# Bus-to-Module Cycle Sequencer

This block turns a host bus data strobe into a single transfer on a slow module-side interface. The host side runs on the system clock. The module side runs on a clock at half that rate, which the block makes by dividing the system clock by two. After the strobe is registered, the block waits for the next module clock rising edge. It then drives one of four select lines for exactly one module clock and watches for the module's acknowledge. Once the acknowledge is seen, it returns the bus acknowledge to the host.

Address decoding is outside this block: the kind of transfer arrives as a 2-bit input. The block holds one write-data latch and one read-data latch. On reads, any data bit the module leaves undriven comes back as one. There are two ways out of a cycle that hangs. With auto-acknowledge enabled, the block gives up after a fixed number of empty acknowledge samples, completes the cycle and flags an error. With it disabled, the block waits until a software reset clears it.

Top module: `bus_mod_sequencer`

## Requirements
- R1: The strobe is registered on the first system clock edge after it rises. The select line becomes visible 2 or 3 system clocks after the strobe is driven high, depending on the clock phase.
- R2: `mod_clk` toggles on every system clock and is high right after reset. The select lines change only on edges where `mod_clk` rises, except when a software reset clears them.
- R3: Exactly one select bit is driven, one-hot from `xfer_kind`: 0 sets bit 0 (I/O), 1 sets bit 1 (ID), 2 sets bit 2 (memory), 3 sets bit 3 (interrupt). It stays high for exactly one module clock, which is two system clocks.
- R4: The acknowledge is sampled on module clock rising edges, starting one module clock after the select drops. If the module raises `mod_ack` 2·W system clocks after the select drops, `bus_ack` appears 2·W+2 system clocks after the select drops.
- R5: With auto-acknowledge disabled and no module acknowledge, `bus_ack` is never driven. The block starts no new select, even if the strobe is released and raised again.
- R6: A one-cycle `soft_rst` returns the block to idle: `bus_ack`, every select and `timeout_err` are low on the next cycle, and the next strobe runs a normal transfer.
- R7: On a completed cycle, `host_rdata` is `mod_rdata` with every bit whose `mod_drive` bit is 0 forced to 1. It is captured at the acknowledge sample.
- R8: With auto-acknowledge enabled, a cycle completes on the 8th consecutive empty acknowledge sample. At that point `bus_ack` rises 16 system clocks after the select drops, `timeout_err` is 1 and `host_rdata` is all ones. An acknowledge that arrives on that same 8th sample wins, with no error.
- R9: `bus_ack` stays high while the strobe is held. It falls 2 system clocks after the strobe drops, and no select occurs while it is high.
- R10: `mod_wr` and `mod_wdata` take `wr_en` and `host_wdata` when the select starts, and hold them until the next select.
- R11: After reset, all outputs except `mod_clk` are zero. `timeout_err` stays set through the acknowledge phase and clears when the next select starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset, returns the sequencer to idle |
| auto_ack_en | input | 1 | Enables timeout completion |
| strobe | input | 1 | Host data strobe, active high |
| xfer_kind | input | 2 | Select type: 0 I/O, 1 ID, 2 memory, 3 interrupt |
| wr_en | input | 1 | 1 for a write cycle |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Latched read data |
| bus_ack | output | 1 | Bus data acknowledge |
| timeout_err | output | 1 | Set when a cycle ended by timeout |
| mod_clk | output | 1 | Module clock, system clock divided by two |
| mod_sel | output | 4 | One-hot module select lines |
| mod_wr | output | 1 | Module write flag |
| mod_wdata | output | DW | Module write data |
| mod_ack | input | 1 | Module acknowledge |
| mod_rdata | input | DW | Module read data |
| mod_drive | input | DW | Per-bit mask of data lines the module drives |

## Verification
The bench builds the block with DW=16 and a timeout of 8 module clocks. With that timeout, the random wait states from 0 to 10 fall on both sides of the limit and include W=7, where the acknowledge and the timeout meet on the same sample. Directed cases cover a module that never answers, with auto-acknowledge both on and off. The bench recovers the hung case with a software reset. Random 16-bit drive masks exercise the fill-with-ones path on reads.

// File: rtl/bus_mod_sequencer.sv
module bus_mod_sequencer #(
  parameter int DW      = 16,
  parameter int TMO_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          auto_ack_en,
  input  logic          strobe,
  input  logic [1:0]    xfer_kind,
  input  logic          wr_en,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          bus_ack,
  output logic          timeout_err,
  output logic          mod_clk,
  output logic [3:0]    mod_sel,
  output logic          mod_wr,
  output logic [DW-1:0] mod_wdata,
  input  logic          mod_ack,
  input  logic [DW-1:0] mod_rdata,
  input  logic [DW-1:0] mod_drive
);
  localparam int CW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_WAIT, S_DONE} st_t;

  st_t           st;
  logic          ph, strb_q, err_q, wr_q;
  logic [CW-1:0] cnt;
  logic [3:0]    sel_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          en;

  assign en          = ph;
  assign mod_clk     = ~ph;
  assign mod_sel     = sel_q;
  assign mod_wr      = wr_q;
  assign mod_wdata   = wd_q;
  assign host_rdata  = rd_q;
  assign bus_ack     = (st == S_DONE);
  assign timeout_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      strb_q <= 1'b0;
      st     <= S_IDLE;
      sel_q  <= '0;
      err_q  <= 1'b0;
      cnt    <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      ph     <= ~ph;
      strb_q <= strobe;
      if (soft_rst) begin
        st    <= S_IDLE;
        sel_q <= '0;
        err_q <= 1'b0;
        cnt   <= '0;
      end else begin
        case (st)
          S_IDLE: if (strb_q && en) begin
            st    <= S_SEL;
            sel_q <= 4'(1) << xfer_kind;
            wr_q  <= wr_en;
            wd_q  <= host_wdata;
            err_q <= 1'b0;
            cnt   <= '0;
          end
          S_SEL: if (en) begin
            st    <= S_WAIT;
            sel_q <= '0;
          end
          S_WAIT: if (en) begin
            if (mod_ack) begin
              st   <= S_DONE;
              rd_q <= mod_rdata | ~mod_drive;
            end else if (cnt == LAST) begin
              if (auto_ack_en) begin
                st    <= S_DONE;
                err_q <= 1'b1;
                rd_q  <= '1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DONE: if (!strb_q) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bus_mod_sequencer_chk.sv
module bus_mod_sequencer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          strobe,
  input logic          bus_ack,
  input logic          timeout_err,
  input logic          mod_clk,
  input logic [3:0]    mod_sel,
  input logic          mod_ack,
  input logic [DW-1:0] host_rdata
);
  a_r2_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mod_clk != $past(mod_clk)));

  a_r2_sel_on_mod_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mod_sel) && !$past(soft_rst)) |-> $rose(mod_clk));

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_sel));

  a_r3_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|mod_sel) && !soft_rst) |=> $stable(mod_sel));

  a_r3_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((|mod_sel) && $past(|mod_sel)) |=> !(|mod_sel));

  a_r5_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> ($past(mod_ack) || timeout_err));

  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!bus_ack && mod_sel == 4'd0 && !timeout_err));

  a_r8_timeout_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> ($rose(bus_ack) && host_rdata == '1));

  a_r9_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && strobe && !soft_rst) |=> bus_ack);

  a_r9_no_sel_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> mod_sel == 4'd0);
endmodule

bind bus_mod_sequencer bus_mod_sequencer_chk #(.DW(DW)) u_chk (.*);

// File: tb/bus_mod_sequencer_bench.sv
module bus_mod_sequencer_bench;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, auto_ack_en = 1'b0, strobe = 1'b0;
  logic [1:0] xfer_kind = '0;
  logic wr_en = 1'b0, mod_ack = 1'b0;
  logic [DW-1:0] host_wdata = '0, mod_rdata = '0, mod_drive = '0;
  logic [DW-1:0] host_rdata, mod_wdata;
  logic bus_ack, timeout_err, mod_clk, mod_wr;
  logic [3:0] mod_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_mod_sequencer #(.DW(DW), .TMO_CYC(8)) u_bus_mod_sequencer (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(input logic [DW-1:0] d, input logic [DW-1:0] m);
    return d | ~m;
  endfunction

  function automatic bit exp_tmo(input bit auto, input bit never, input int w);
    return auto && (never || w >= 8);
  endfunction

  task automatic run_xfer(input int kind, input bit wr, input logic [DW-1:0] wd,
                          input logic [DW-1:0] rd, input logic [DW-1:0] drv,
                          input int w, input bit auto, input bit never, input int hold);
    int n = 0, lat = 0;
    bit tmo = exp_tmo(auto, never, w);
    @(negedge clk);
    xfer_kind = 2'(kind); wr_en = wr; host_wdata = wd; auto_ack_en = auto; strobe = 1'b1;
    while (mod_sel == 4'd0 && n < 10) begin @(negedge clk); n++; end
    chk(n == 2 || n == 3, "R1 strobe-to-select delay", n, 2);
    chk(mod_clk == 1'b1, "R2 select on module edge", mod_clk, 1);
    chk(mod_sel == 4'(1) << kind, "R3 one-hot select", mod_sel, 4'(1) << kind);
    chk(mod_wr == wr && mod_wdata == wd, "R10 write latch", {mod_wr, mod_wdata}, {wr, wd});
    chk(timeout_err == 1'b0, "R11 error cleared at select", timeout_err, 0);
    @(negedge clk);
    chk(mod_sel == 4'(1) << kind, "R3 select second cycle", mod_sel, 4'(1) << kind);
    @(negedge clk);
    chk(mod_sel == 4'd0, "R3 select length", mod_sel, 0);
    forever begin
      if (!never && lat == 2*w) begin mod_ack = 1'b1; mod_rdata = rd; mod_drive = drv; end
      if (bus_ack || lat >= 60) break;
      @(negedge clk); lat++;
    end
    if (never && !auto) begin
      chk(bus_ack == 1'b0, "R5 no acknowledge when hung", bus_ack, 0);
      return;
    end
    if (tmo) begin
      chk(lat == 16, "R8 timeout latency", lat, 16);
      chk(timeout_err == 1'b1, "R8 error flag", timeout_err, 1);
      chk(host_rdata == '1, "R8 read all ones", host_rdata, 16'hFFFF);
    end else begin
      chk(lat == 2*w + 2, "R4 acknowledge latency", lat, 2*w + 2);
      chk(timeout_err == 1'b0, "R8 no error when acknowledged", timeout_err, 0);
      if (!wr) chk(host_rdata == exp_rd(rd, drv), "R7 undriven bits read one", host_rdata, exp_rd(rd, drv));
    end
    mod_ack = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(bus_ack == 1'b1 && mod_sel == 4'd0, "R9 acknowledge held", {bus_ack, mod_sel}, 5'h10);
    end
    strobe = 1'b0;
    @(negedge clk);
    chk(bus_ack == 1'b1, "R9 acknowledge one cycle after release", bus_ack, 1);
    @(negedge clk);
    chk(bus_ack == 1'b0, "R9 acknowledge falls", bus_ack, 0);
    if (tmo) chk(timeout_err == 1'b1, "R11 error kept until next select", timeout_err, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(bus_ack == 0 && mod_sel == 0 && timeout_err == 0, "R11 reset outputs", {bus_ack, mod_sel, timeout_err}, 0);
    chk(host_rdata == 0 && mod_wr == 0 && mod_wdata == 0, "R11 reset data", host_rdata, 0);
    chk(mod_clk == 1'b1, "R2 module clock after reset", mod_clk, 1);
    rst_n = 1'b1;
    // directed: zero wait, boundary W=7, timeout, kinds
    run_xfer(0, 0, 16'h1234, 16'hA5A5, 16'hFFFF, 0, 1, 0, 1);
    run_xfer(1, 0, 16'h0000, 16'h00F0, 16'h0FF0, 7, 1, 0, 0);
    run_xfer(2, 1, 16'hBEEF, 16'h0000, 16'h0000, 8, 1, 0, 2);
    run_xfer(3, 0, 16'h0001, 16'h1111, 16'hFFFF, 0, 1, 1, 0);
    run_xfer(2, 0, 16'h0000, 16'h5555, 16'h00FF, 11, 0, 0, 1);
    // R5: hung cycle, then R6 recovery
    run_xfer(1, 0, 16'h0000, 16'h0000, 16'h0000, 0, 0, 1, 0);
    strobe = 1'b0;
    repeat (4) @(negedge clk);
    strobe = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(mod_sel == 0 && bus_ack == 0, "R5 stays waiting", {bus_ack, mod_sel}, 0);
    end
    strobe = 1'b0;
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    chk(bus_ack == 0 && mod_sel == 0 && timeout_err == 0, "R6 soft reset idle", {bus_ack, mod_sel, timeout_err}, 0);
    run_xfer(0, 1, 16'hC3C3, 16'h0000, 16'hFFFF, 1, 0, 0, 0); // R6 next transfer runs
    for (int t = 0; t < 40; t++) begin
      run_xfer(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 16'($urandom),
               16'($urandom), 16'($urandom), int'($urandom_range(0, 10)),
               1'($urandom_range(0, 1)), 1'b0, int'($urandom_range(0, 3)));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule